// File: doc/BRIEF.md
# Cascadable LCD Segment Data Loader

This block is the digital segment-side data path of an 80-column dot-matrix LCD column driver. Display data arrives on a shift strobe, either a 4-bit nibble or a single bit per strobe. The order in which columns fill depends on both the width mode and a direction input. A line latch strobe copies the assembled row into an output latch. Each column then presents a 2-bit code that selects one of four drive levels. The code follows the frame alternation input, the latched bit and a display enable.

Several loaders can share one data bus when they are chained through their enable pins. A loader accepts strobes only while its incoming enable is low. Once its row is full, it pulls its outgoing enable low so that the next device in the chain takes over. A high level on the latch strobe re-arms the chain for the next line. The direction input decides which of the two enable pins is the input and which is the output.

Top module: `lcd_seg_loader`

## Requirements
- R1: Nibble mode (`serial_mode`=0), `dir_rev`=0: a row takes 20 accepted strobes. Bit j (0..3) of the nibble on the k-th accepted strobe (k=0..19) lands in column 4k+j+1.
- R2: Nibble mode, `dir_rev`=1: bit j of the nibble on the k-th accepted strobe lands in column 80-4k-j. So the first nibble fills columns 80 down to 77 and the last fills columns 4 down to 1.
- R3: Serial mode (`serial_mode`=1), `dir_rev`=0: a row takes 80 accepted strobes of `data_in[0]`. The k-th accepted bit (k=0..79) lands in column 80-k.
- R4: Serial mode, `dir_rev`=1: the k-th accepted bit lands in column k+1.
- R5: The output latch copies the shift register only on the cycle after `latch_clk` falls. Shifting alone leaves `level_o` unchanged.
- R6: A strobe that arrives while the selected enable input is high does not change the shift register.
- R7: Enable pin roles follow the direction input. With `dir_rev`=0, `en_left_i` is the input and `en_right_o` is the output. With `dir_rev`=1 the roles swap. The unselected input has no effect, and the unselected output stays high.
- R8: One cycle after the last accepted strobe of a row (the 20th or the 80th), the active enable output goes low. Strobes that arrive while it is low are ignored.
- R9: While `latch_clk` is high, the active enable output returns high, the strobe count restarts and strobes are ignored.
- R10: Column c uses bits [2c-1:2c-2] of `level_o`. With `disp_on`=1 the code is: M=0 and bit=0 gives 2'b01; M=0 and bit=1 gives 2'b00; M=1 and bit=0 gives 2'b10; M=1 and bit=1 gives 2'b11.
- R11: With `disp_on`=0, every column code is 2'b00.
- R12: A synchronous active-low reset clears the shift register, the latch and the fill state. After reset both enable outputs are high, and with M=0 and `disp_on`=1 every code is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | One-cycle data shift strobe |
| latch_clk | input | 1 | Line latch level; its falling edge latches the row, and a high level re-arms the chain |
| data_in | input | 4 | Nibble data; bit 0 is the serial input |
| serial_mode | input | 1 | 1 = one bit per strobe, 0 = four bits per strobe |
| dir_rev | input | 1 | Fill direction and enable pin role select |
| en_left_i | input | 1 | Left enable input (active low) |
| en_right_i | input | 1 | Right enable input (active low) |
| en_left_o | output | 1 | Left enable output (low = pass to next device) |
| en_right_o | output | 1 | Right enable output (low = pass to next device) |
| frame_m | input | 1 | Frame alternation signal |
| disp_on | input | 1 | 0 forces all columns to code 2'b00 |
| level_o | output | 160 | Per-column 2-bit drive level codes |

## Verification
The assertions assume four things about the inputs:
- `shift_stb` is a single-cycle pulse.
- `serial_mode` and `dir_rev` stay constant within a line.
- `latch_clk` stays high for at least one full cycle.
- No strobe coincides with the falling latch edge.

The stimulus holds the mode and direction for a whole line and drives every strobe as a one-cycle pulse. It inserts random idle gaps, random disabled strobes (with the unselected pin driven to the opposite level), one extra strobe after the row is full, and one strobe during the latch-high phase. After the row has been latched it picks the frame and display-enable values at random.

// File: rtl/lcd_seg_pkg.sv
// Package: shared level code type and the per-column level selection.
// Assumes the four drive levels are ordered V0, V12, V43, V5 in code space.
package lcd_seg_pkg;

    typedef enum logic [1:0] {
        LVL_V0  = 2'b00,
        LVL_V12 = 2'b01,
        LVL_V43 = 2'b10,
        LVL_V5  = 2'b11
    } lvl_e;

    // Pick the drive level for one column from frame, latched bit and display enable.
    function automatic lvl_e pick_level(input logic frame_m, input logic bit_on,
                                        input logic disp_on);
        lvl_e lv;
        if (!disp_on)
            lv = LVL_V0;
        else if (!frame_m)
            lv = bit_on ? LVL_V0 : LVL_V12;
        else
            lv = bit_on ? LVL_V5 : LVL_V43;
        return lv;
    endfunction

endpackage

// File: rtl/lcd_seg_ctrl.sv
// Module: lcd_seg_ctrl
// Counts accepted shift strobes, tracks when the row is full, passes the
// enable token on, and detects the falling edge of the latch strobe.
// Assumes shift_stb is a one-cycle pulse and that the mode inputs stay
// constant within a line.
module lcd_seg_ctrl #(
    parameter int NUM_COLS = 80,
    parameter int NIB_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_stb,
    input  logic latch_clk,
    input  logic serial_mode,
    input  logic dir_rev,
    input  logic en_left_i,
    input  logic en_right_i,
    output logic shift_en,
    output logic latch_fire,
    output logic en_left_o,
    output logic en_right_o
);
    localparam int NIB_COUNT = NUM_COLS / NIB_W;
    localparam int CNT_W     = $clog2(NUM_COLS + 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] target;
    logic             full_q;
    logic             lat_prev_q;
    logic             en_in;

    // Strobe count that completes a row in the current width mode.
    always_comb target = serial_mode ? CNT_W'(NUM_COLS) : CNT_W'(NIB_COUNT);

    // Select the enable input according to the direction.
    always_comb en_in = dir_rev ? en_right_i : en_left_i;

    // Accept a strobe only when enabled, not full and not in the latch-high phase.
    always_comb shift_en = shift_stb && !en_in && !full_q && !latch_clk;

    // Count accepted strobes and mark the row full; a high latch level re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            full_q  <= 1'b0;
        end else if (latch_clk) begin
            count_q <= '0;
            full_q  <= 1'b0;
        end else if (shift_en) begin
            count_q <= count_q + CNT_W'(1);
            if (count_q + CNT_W'(1) >= target)
                full_q <= 1'b1;
        end
    end

    // Remember the previous latch level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_prev_q <= 1'b0;
        else
            lat_prev_q <= latch_clk;
    end

    // Falling edge of the latch strobe.
    always_comb latch_fire = lat_prev_q && !latch_clk;

    // Drive the enable output on the side selected by the direction; hold the other high.
    always_comb begin
        en_left_o  = dir_rev ? !full_q : 1'b1;
        en_right_o = dir_rev ? 1'b1 : !full_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(NUM_COLS)); // R8
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !latch_clk) |=> full_q); // R8
    AST_LATCH_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clk |=> (!full_q && count_q == '0)); // R9
    AST_EN_OUT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_left_o, en_right_o}) >= 1); // R7

endmodule

// File: rtl/lcd_seg_shreg.sv
// Module: lcd_seg_shreg
// Row shift register. Index 0 is column 1. The entry point and the shift
// direction depend on the width mode and the direction input.
// Assumes shift_en is already gated by enable and fill state.
module lcd_seg_shreg #(
    parameter int NUM_COLS = 80,
    parameter int NIB_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                serial_mode,
    input  logic                dir_rev,
    input  logic [NIB_W-1:0]    data_in,
    output logic [NUM_COLS-1:0] sr_q
);
    logic [NIB_W-1:0]    nib_rev;
    logic [NUM_COLS-1:0] nxt_pf, nxt_pr, nxt_sf, nxt_sr, nxt;

    // Reverse the nibble so that its last bit enters at column 1.
    for (genvar j = 0; j < NIB_W; j++) begin : g_rev
        assign nib_rev[j] = data_in[NIB_W-1-j];
    end

    // Candidate next states for the four load orderings.
    always_comb begin
        nxt_pf = {data_in, sr_q[NUM_COLS-1:NIB_W]};
        nxt_pr = {sr_q[NUM_COLS-NIB_W-1:0], nib_rev};
        nxt_sf = {sr_q[NUM_COLS-2:0], data_in[0]};
        nxt_sr = {data_in[0], sr_q[NUM_COLS-1:1]};
    end

    // Choose the ordering from width mode and direction.
    always_comb begin
        case ({serial_mode, dir_rev})
            2'b00:   nxt = nxt_pf;
            2'b01:   nxt = nxt_pr;
            2'b10:   nxt = nxt_sf;
            default: nxt = nxt_sr;
        endcase
    end

    // Shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= nxt;
    end

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q)); // R6

endmodule

// File: rtl/lcd_seg_outstage.sv
// Module: lcd_seg_outstage
// Holds the latched row and maps each column to its 2-bit level code.
// Assumes latch_fire is a one-cycle pulse from the edge detector.
module lcd_seg_outstage #(
    parameter int NUM_COLS = 80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  latch_fire,
    input  logic [NUM_COLS-1:0]   sr_q,
    input  logic                  frame_m,
    input  logic                  disp_on,
    output logic [2*NUM_COLS-1:0] level_o
);
    import lcd_seg_pkg::*;

    logic [NUM_COLS-1:0] lat_q;

    // Output latch loaded on the latch strobe's falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (latch_fire)
            lat_q <= sr_q;
    end

    // Per-column level selection.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign level_o[2*c +: 2] = pick_level(frame_m, lat_q[c], disp_on);
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_fire |=> $stable(lat_q)); // R5
    AST_DISP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |-> (level_o == '0)); // R11

endmodule

// File: rtl/lcd_seg_loader.sv
// Module: lcd_seg_loader (top)
// Segment data loader: strobe-driven row fill with a cascade enable, a line
// latch, and per-column level codes.
// Assumes strobes are one-cycle pulses in the clk domain.
module lcd_seg_loader #(
    parameter int NUM_COLS = 80,
    parameter int NIB_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_stb,
    input  logic                  latch_clk,
    input  logic [NIB_W-1:0]      data_in,
    input  logic                  serial_mode,
    input  logic                  dir_rev,
    input  logic                  en_left_i,
    input  logic                  en_right_i,
    output logic                  en_left_o,
    output logic                  en_right_o,
    input  logic                  frame_m,
    input  logic                  disp_on,
    output logic [2*NUM_COLS-1:0] level_o
);
    logic                shift_en;
    logic                latch_fire;
    logic [NUM_COLS-1:0] sr_q;

    lcd_seg_ctrl #(.NUM_COLS(NUM_COLS), .NIB_W(NIB_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .latch_clk(latch_clk),
        .serial_mode(serial_mode), .dir_rev(dir_rev),
        .en_left_i(en_left_i), .en_right_i(en_right_i),
        .shift_en(shift_en), .latch_fire(latch_fire),
        .en_left_o(en_left_o), .en_right_o(en_right_o)
    );

    lcd_seg_shreg #(.NUM_COLS(NUM_COLS), .NIB_W(NIB_W)) shreg_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .serial_mode(serial_mode), .dir_rev(dir_rev),
        .data_in(data_in), .sr_q(sr_q)
    );

    lcd_seg_outstage #(.NUM_COLS(NUM_COLS)) out_i (
        .clk(clk), .rst_n(rst_n), .latch_fire(latch_fire), .sr_q(sr_q),
        .frame_m(frame_m), .disp_on(disp_on), .level_o(level_o)
    );

endmodule

// File: tb/lcd_seg_loader_tb_top.sv
module lcd_seg_loader_tb_top;
    localparam int NC = 80;
    localparam int NW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0, shift_stb = 1'b0, latch_clk = 1'b0;
    logic [NW-1:0] data_in = '0;
    logic          serial_mode = 1'b0, dir_rev = 1'b0;
    logic          en_left_i = 1'b1, en_right_i = 1'b1;
    logic          en_left_o, en_right_o;
    logic          frame_m = 1'b0, disp_on = 1'b1;
    logic [2*NC-1:0] level_o;

    int total = 0, bad = 0;
    logic [NC-1:0] exp_cols, prev_cols;

    lcd_seg_loader #(.NUM_COLS(NC), .NIB_W(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .latch_clk(latch_clk),
        .data_in(data_in), .serial_mode(serial_mode), .dir_rev(dir_rev),
        .en_left_i(en_left_i), .en_right_i(en_right_i),
        .en_left_o(en_left_o), .en_right_o(en_right_o),
        .frame_m(frame_m), .disp_on(disp_on), .level_o(level_o)
    );

    // Level codes from the R10/R11 table.
    function automatic logic [2*NC-1:0] exp_levels(input logic [NC-1:0] cols,
                                                   input logic m, input logic don);
        logic [2*NC-1:0] v;
        for (int c = 0; c < NC; c++) begin
            if (!don)   v[2*c +: 2] = 2'b00;
            else if (m) v[2*c +: 2] = cols[c] ? 2'b11 : 2'b10;
            else        v[2*c +: 2] = cols[c] ? 2'b00 : 2'b01;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [2*NC-1:0] act, input logic [2*NC-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive the enable input selected by the direction; the other pin gets the opposite level.
    task automatic set_en(input logic v);
        if (dir_rev) begin en_right_i = v; en_left_i = ~v; end
        else         begin en_left_i = v;  en_right_i = ~v; end
    endtask

    task automatic strobe(input logic [NW-1:0] d);
        @(negedge clk); data_in = d; shift_stb = 1'b1;
        @(negedge clk); shift_stb = 1'b0;
    endtask

    task automatic load_line(input logic ser, input logic dir);
        int n;
        logic [NW-1:0] d;
        logic act_out, idle_out;
        string rq;
        n = ser ? NC : NC / NW;
        rq = ser ? (dir ? "R4" : "R3") : (dir ? "R2" : "R1");
        @(negedge clk);
        serial_mode = ser; dir_rev = dir; exp_cols = '0;
        set_en(1'b0);
        for (int k = 0; k < n; k++) begin
            if ($urandom % 4 == 0) begin
                set_en(1'b1);                 // R6: disabled strobe must be ignored
                strobe(NW'($urandom));
                set_en(1'b0);
            end
            if ($urandom % 3 == 0) @(negedge clk);
            d = NW'($urandom);
            strobe(d);
            for (int j = 0; j < NW; j++) begin
                if (!ser && !dir) exp_cols[NW*k + j] = d[j];
                if (!ser && dir)  exp_cols[NC-1-NW*k-j] = d[j];
            end
            if (ser && !dir) exp_cols[NC-1-k] = d[0];
            if (ser && dir)  exp_cols[k] = d[0];
        end
        act_out  = dir ? en_left_o : en_right_o;
        idle_out = dir ? en_right_o : en_left_o;
        chk(act_out == 1'b0, "R8", {159'b0, act_out}, '0);
        chk(idle_out == 1'b1, "R7", {159'b0, idle_out}, {159'b0, 1'b1});
        chk(level_o == exp_levels(prev_cols, frame_m, disp_on), "R5",
            level_o, exp_levels(prev_cols, frame_m, disp_on));
        strobe(NW'($urandom));                // R8: strobe while full is ignored
        @(negedge clk); latch_clk = 1'b1;
        @(negedge clk);
        act_out = dir ? en_left_o : en_right_o;
        chk(act_out == 1'b1, "R9", {159'b0, act_out}, {159'b0, 1'b1});
        data_in = NW'($urandom); shift_stb = 1'b1;  // R9: strobe during latch high ignored
        @(negedge clk); shift_stb = 1'b0; latch_clk = 1'b0;
        @(negedge clk);
        chk(level_o == exp_levels(exp_cols, frame_m, disp_on), rq,
            level_o, exp_levels(exp_cols, frame_m, disp_on));
        prev_cols = exp_cols;
        frame_m = 1'($urandom); disp_on = ($urandom % 4) != 0;
        @(negedge clk);
        chk(level_o == exp_levels(exp_cols, frame_m, disp_on), disp_on ? "R10" : "R11",
            level_o, exp_levels(exp_cols, frame_m, disp_on));
        disp_on = 1'b1;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        prev_cols = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(en_left_o && en_right_o, "R12", {158'b0, en_left_o, en_right_o}, {158'b0, 2'b11});
        chk(level_o == exp_levels('0, 1'b0, 1'b1), "R12", level_o, exp_levels('0, 1'b0, 1'b1));
        for (int r = 0; r < 3; r++) begin
            load_line(1'b0, 1'b0);
            load_line(1'b0, 1'b1);
            load_line(1'b1, 1'b0);
            load_line(1'b1, 1'b1);
        end
        frame_m = 1'b0; disp_on = 1'b0;       // R11 directed
        @(negedge clk);
        chk(level_o == '0, "R11", level_o, '0);
        frame_m = 1'b1; disp_on = 1'b1;       // R10 directed
        @(negedge clk);
        chk(level_o == exp_levels(prev_cols, 1'b1, 1'b1), "R10",
            level_o, exp_levels(prev_cols, 1'b1, 1'b1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule